// File: doc/BRIEF.md
# RISC Execute Unit with Barrel Shifter and Condition Flags

This block is the arithmetic and logic stage of a 32-bit load/store processor. Each cycle it takes two 32-bit operands, a 5-bit function code and a 2-bit shift select, and returns a 32-bit result. The result is combinational. Operand B arrives already selected and, where it is an immediate, already sign extended by the decode stage.

The function code is orthogonal. Bits [1:0] choose the result group: 00 adder, 01 AND, 10 OR, 11 XOR. Bit 2 inverts operand B, which gives subtract, ANDN, ORN and XNOR. Bit 3 feeds the stored carry into the adder. Bit 4 asks for the condition flags to be written.

When the shift select is nonzero, the barrel shifter drives the result instead of the ALU. The four flags (carry, overflow, negative, zero) are registered. An operation can be issued only for its effect on the flags, with its result discarded.

Top module: `risc_exec_unit`

## Requirements
- R1: func[1:0] selects the result: 00 adder, 01 a AND b', 10 a OR b', 11 a XOR b'. Here b' is ~b when func[2]=1 and b otherwise, so 00101 gives ANDN, 00110 gives ORN and 00111 gives XNOR.
- R2: With func[3]=0, code 00000 yields a+b and code 00100 yields a−b, computed as a+~b+1 and taken modulo 2^32.
- R3: With func[3]=1, code 01000 yields a+b+C and code 01100 yields a−b−C, computed as a+~b+~C, where C is the stored carry flag.
- R4: The flags change only at a rising clock edge where func[4]=1 and shift_sel=00. At every other edge they hold their value.
- R5: An adder cc operation writes C as follows. For add forms, C is the carry out of bit 31. For subtract forms, C is the borrow, which is the inverse of the carry out.
- R6: An adder cc operation writes V as the signed overflow of the addition it performs, N as result bit 31, and Z as 1 when the 32-bit result is zero.
- R7: A logic cc operation (func[4]=1, func[1:0]≠00) clears C, V, N and Z to 0.
- R8: A nonzero shift_sel overrides the ALU result: 01 shifts left logical, 10 shifts right logical, and 11 shifts right arithmetic with bit 31 replicated. The shift amount is opb[4:0].
- R9: Active-low reset clears all four flags to 0.
- R10: The result follows the inputs in the same cycle. A flag write appears only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flags |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B (register or pre-extended immediate) |
| func | input | 5 | Function code: group, invert, carry-in, flag write |
| shift_sel | input | 2 | 00 ALU, 01 SLL, 10 SRL, 11 SRA |
| result | output | 32 | Destination value |
| flag_c | output | 1 | Stored carry / borrow |
| flag_v | output | 1 | Stored signed overflow |
| flag_n | output | 1 | Stored negative |
| flag_z | output | 1 | Stored zero |

## Verification
The bench goes after the carry sense of subtraction. A design that stored the raw carry out would report no borrow for 3−5, and would make the extended subtract one too large.

It chains cc and extended operations so that a wrong carry-in polarity surfaces as an off-by-one sum. It checks wraparound to zero and signed overflow at 0x7FFFFFFF+1. It also checks that shifts and non-cc codes leave the flags untouched, which catches a design that writes flags whenever func[4] is set.

For the shifter, it checks shift amounts of 0 and 31, the use of only the low five bits of operand B, and sign fill on arithmetic right shifts. A logical right shift that smeared bit 31 would fail here.

// File: rtl/risc_exec_unit.sv
module risc_exec_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [4:0]   func,
  input  logic [1:0]   shift_sel,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_v,
  output logic         flag_n,
  output logic         flag_z
);
  localparam int SW = $clog2(W);

  logic [W-1:0] b_eff, alu_out, shf_out, sum;
  logic         cin, cout, ovf, is_sub, use_c, wr_flags, is_logic;
  logic [SW-1:0] amt;

  assign is_sub   = func[2];
  assign use_c    = func[3];
  assign is_logic = func[1:0] != 2'b00;
  assign b_eff    = is_sub ? ~opb : opb;
  assign cin      = use_c ? (flag_c ^ is_sub) : is_sub;
  assign {cout, sum} = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign ovf      = (opa[W-1] == b_eff[W-1]) && (sum[W-1] != opa[W-1]);

  always_comb begin
    case (func[1:0])
      2'b00:   alu_out = sum;
      2'b01:   alu_out = opa & b_eff;
      2'b10:   alu_out = opa | b_eff;
      default: alu_out = opa ^ b_eff;
    endcase
  end

  assign amt = opb[SW-1:0];
  always_comb begin
    case (shift_sel)
      2'b01:   shf_out = opa << amt;
      2'b10:   shf_out = opa >> amt;
      2'b11:   shf_out = $signed(opa) >>> amt;
      default: shf_out = '0;
    endcase
  end

  assign result   = (shift_sel == 2'b00) ? alu_out : shf_out;
  assign wr_flags = func[4] && (shift_sel == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_c <= 1'b0;
      flag_v <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (wr_flags) begin
      if (is_logic) begin
        flag_c <= 1'b0;
        flag_v <= 1'b0;
        flag_n <= 1'b0;
        flag_z <= 1'b0;
      end else begin
        flag_c <= cout ^ is_sub;
        flag_v <= ovf;
        flag_n <= sum[W-1];
        flag_z <= (sum == '0);
      end
    end
  end

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(func[4] && shift_sel == 2'b00) |=> $stable({flag_c, flag_v, flag_n, flag_z}));

  // R7
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func[4] && shift_sel == 2'b00 && func[1:0] != 2'b00) |=> ({flag_c, flag_v, flag_n, flag_z} == 4'b0000));

  // R6
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func[4] && shift_sel == 2'b00 && func[1:0] == 2'b00) |=> (flag_n == $past(result[W-1])));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func[4] && shift_sel == 2'b00 && func[1:0] == 2'b00) |=> (flag_z == ($past(result) == '0)));

  // R8
  shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_sel != 2'b00 && opa == '0) |-> (result == '0));

  // R2
  add_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_sel == 2'b00 && func[3:0] == 4'b0000) |-> (result == opa + opb));
endmodule

// File: tb/risc_exec_unit_tb.sv
module risc_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [4:0]  func = '0;
  logic [1:0]  shift_sel = '0;
  logic [31:0] result;
  logic        flag_c, flag_v, flag_n, flag_z;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  risc_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .func(func),
    .shift_sel(shift_sel), .result(result), .flag_c(flag_c),
    .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z)
  );

  // a, b, func, shift_sel, expected result
  localparam int NV = 14;
  localparam logic [102:0] VEC [NV] = '{
    {32'd5,          32'd3,          5'b00000, 2'b00, 32'd8},          // R2 add
    {32'd5,          32'd3,          5'b00100, 2'b00, 32'd2},          // R2 sub
    {32'd3,          32'd5,          5'b00100, 2'b00, 32'hFFFF_FFFE},  // R2 sub negative
    {32'hF0F0_F0F0,  32'hFF00_FF00,  5'b00001, 2'b00, 32'hF000_F000},  // R1 and
    {32'hF0F0_F0F0,  32'hFF00_FF00,  5'b00101, 2'b00, 32'h00F0_00F0},  // R1 andn
    {32'hF0F0_F0F0,  32'hFF00_FF00,  5'b00010, 2'b00, 32'hFFF0_FFF0},  // R1 or
    {32'hF0F0_F0F0,  32'hFF00_FF00,  5'b00110, 2'b00, 32'hF0FF_F0FF},  // R1 orn
    {32'hF0F0_F0F0,  32'hFF00_FF00,  5'b00011, 2'b00, 32'h0FF0_0FF0},  // R1 xor
    {32'hF0F0_F0F0,  32'hFF00_FF00,  5'b00111, 2'b00, 32'hF00F_F00F},  // R1 xnor
    {32'h8000_0001,  32'd4,          5'b00000, 2'b01, 32'h0000_0010},  // R8 sll
    {32'h8000_0010,  32'd4,          5'b00000, 2'b10, 32'h0800_0001},  // R8 srl
    {32'h8000_0010,  32'd4,          5'b00000, 2'b11, 32'hF800_0001},  // R8 sra
    {32'h1234_5678,  32'h0000_0020,  5'b00000, 2'b01, 32'h1234_5678},  // R8 amount uses low 5 bits
    {32'h0000_0001,  32'd31,         5'b00000, 2'b01, 32'h8000_0000}   // R8 shift by 31
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // drive at negedge, check result, then check flags after the edge
  task automatic op(input logic [31:0] a, input logic [31:0] b, input logic [4:0] f,
                    input logic [1:0] s, input logic [31:0] exp_res,
                    input logic [3:0] exp_cvnz, input string tag);
    @(negedge clk);
    opa = a; opb = b; func = f; shift_sel = s;
    #1 chk({tag, " result"}, result, exp_res);
    @(posedge clk); #1;
    chk({tag, " flags cvnz"}, {28'd0, flag_c, flag_v, flag_n, flag_z}, {28'd0, exp_cvnz});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 chk("R9 reset flags", {28'd0, flag_c, flag_v, flag_n, flag_z}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      opa = VEC[i][102:71]; opb = VEC[i][70:39];
      func = VEC[i][38:34]; shift_sel = VEC[i][33:32];
      #1 chk($sformatf("R1/R2/R8 vector %0d", i), result, VEC[i][31:0]);
    end

    // R10: result immediate, flags unchanged until the edge
    @(negedge clk);
    opa = 32'hFFFF_FFFF; opb = 32'd1; func = 5'b10000; shift_sel = 2'b00;
    #1 chk("R10 result same cycle", result, 32'd0);
    chk("R10 flags before edge", {28'd0, flag_c, flag_v, flag_n, flag_z}, 32'd0);
    @(posedge clk); #1;
    chk("R5 R6 addcc wrap flags", {28'd0, flag_c, flag_v, flag_n, flag_z}, 32'b1001);

    op(32'd5,          32'd3, 5'b01000, 2'b00, 32'd9,          4'b1001, "R3 R4 addx carry in");
    op(32'd10,         32'd3, 5'b01100, 2'b00, 32'd6,          4'b1001, "R3 subx borrow in");
    op(32'd3,          32'd5, 5'b10100, 2'b00, 32'hFFFF_FFFE,  4'b1010, "R5 subcc borrow");
    op(32'h7FFF_FFFF,  32'd1, 5'b10000, 2'b00, 32'h8000_0000,  4'b0110, "R6 addcc overflow");
    op(32'd3,          32'd1, 5'b10000, 2'b01, 32'd6,          4'b0110, "R4 R8 shift holds flags");
    op(32'd0,          32'd1, 5'b10100, 2'b00, 32'hFFFF_FFFF,  4'b1010, "R5 subcc 0-1");
    op(32'hFFFF_FFFF,  32'hFFFF_FFFF, 5'b10001, 2'b00, 32'hFFFF_FFFF, 4'b0000, "R7 andcc clears");
    op(32'd0,          32'd1, 5'b10100, 2'b00, 32'hFFFF_FFFF,  4'b1010, "R5 subcc set borrow");
    op(32'd5,          32'd5, 5'b11100, 2'b00, 32'hFFFF_FFFF,  4'b1010, "R3 R5 subxcc");
    op(32'hFFFF_FFFF,  32'd0, 5'b11000, 2'b00, 32'd0,          4'b1001, "R3 R6 addxcc wrap");
    op(32'h8000_0000,  32'd1, 5'b00001, 2'b00, 32'd0,          4'b1001, "R4 non-cc logic holds");

    @(negedge clk) rst_n = 1'b0;
    #1 chk("R9 async reset clears", {28'd0, flag_c, flag_v, flag_n, flag_z}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    done = 1;
    finish_run();
  end
endmodule